// File: doc/BRIEF.md
# Strided Vector Load Controller with Banked Memory

This block turns one strided vector load command into a stream of single-word requests to an interleaved memory of eight banks. Element i sits at word address base + i*stride. The low address bits pick the bank, and the upper bits give the row inside that bank. Each bank needs a fixed recovery time after it is accessed. The controller keeps one down-counter per bank and holds the next element back while its bank is still recovering. Because of this, a stride that returns to the same bank too soon costs stall cycles.

Memory answers come back in the order the requests were issued. The controller writes each answer into the next slot of an internal vector register. The register has a read port by index. When the last element has been written, the controller raises done.

Top module: `strided_vload_ctrl`

## Requirements
- R1: Element i is requested at word address (base + i*stride) modulo 2^ADDR_W. The bank is address bits [2:0], and bank_row carries the address bits above those three.
- R2: Elements are requested strictly in index order. At most one bit of bank_req is high in any cycle, and bit b means a request to bank b.
- R3: Once bank b has been requested, it is not requested again for the next BUSY-1 cycles (BUSY = 7). If an element is waiting for that bank, it is issued in the BUSY-th cycle after the earlier request.
- R4: stall is high in exactly those cycles in which an element is still waiting and its bank is recovering. For a vector of n elements, stride 1 gives 0 stall cycles and stride 8 gives (n-1)*(BUSY-1) stall cycles.
- R5: Each word that arrives with ret_valid is written into vector slot 0, 1, 2, ... in arrival order. rd_data shows the slot selected by rd_idx.
- R6: done is low while a load runs. It goes high in the cycle after the last element's word is captured, and it stays high until the next accepted start.
- R7: After reset, bank_req is all zero and stall and done are low.
- R8: Vector lengths from 1 to 64 are supported. A length of 1 issues exactly one request.
- R9: A start pulse during a running load is ignored, and the running load continues unchanged.
- R10: A start accepted at a clock edge makes the first request visible in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load with the base, stride and vlen values present at that edge |
| base | input | ADDR_W | Word address of element 0 |
| stride | input | ADDR_W | Word distance between consecutive elements |
| vlen | input | 7 | Number of elements, 1 to 64 |
| bank_req | output | BANKS | One-hot bank request for the current element |
| bank_row | output | ADDR_W-3 | Row inside the selected bank |
| stall | output | 1 | The pending element is blocked by a recovering bank |
| ret_valid | input | 1 | A returned word is present |
| ret_data | input | DATA_W | The returned word |
| rd_idx | input | 6 | Vector register slot to read |
| rd_data | output | DATA_W | Contents of the selected slot |
| done | output | 1 | All elements of the last load have been written |

## Verification
Requests and stall are combinational from the controller state. The bench therefore compares them with its own bank-counter model at every falling edge, starting with the first cycle after start. The model advances its counters once per cycle, in the same way as the edge it stands for.

The bench's memory returns each word one cycle after the request. So done is due at the falling edge that follows the edge capturing the last word, and that is where it is sampled. The register contents are read through rd_idx after done, when no more writes can occur. The bench settles the read path for 1 ns before it samples.

// File: rtl/strided_vload_ctrl.sv
module strided_vload_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int BANKS  = 8,
  parameter int BUSY   = 7,
  parameter int MAX_VL = 64
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic [ADDR_W-1:0]                base,
  input  logic [ADDR_W-1:0]                stride,
  input  logic [$clog2(MAX_VL):0]          vlen,
  output logic [BANKS-1:0]                 bank_req,
  output logic [ADDR_W-$clog2(BANKS)-1:0]  bank_row,
  output logic                             stall,
  input  logic                             ret_valid,
  input  logic [DATA_W-1:0]                ret_data,
  input  logic [$clog2(MAX_VL)-1:0]        rd_idx,
  output logic [DATA_W-1:0]                rd_data,
  output logic                             done
);
  localparam int BSEL_W = $clog2(BANKS);
  localparam int IDX_W  = $clog2(MAX_VL);
  localparam int VL_W   = IDX_W + 1;
  localparam int CNT_W  = $clog2(BUSY + 1);

  logic              active;
  logic [ADDR_W-1:0] addr, stride_q;
  logic [VL_W-1:0]   vl_q, iss_cnt, wr_cnt;
  logic [CNT_W-1:0]  cnt [BANKS];
  logic [DATA_W-1:0] vreg [MAX_VL];

  wire [BSEL_W-1:0] tgt     = addr[BSEL_W-1:0];
  wire              pending = active && (iss_cnt < vl_q);
  wire              free    = (cnt[tgt] == '0);
  wire              issue   = pending && free;

  assign stall    = pending && !free;
  assign bank_row = addr[ADDR_W-1:BSEL_W];
  assign rd_data  = vreg[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      done     <= 1'b0;
      addr     <= '0;
      stride_q <= '0;
      vl_q     <= '0;
      iss_cnt  <= '0;
      wr_cnt   <= '0;
    end else if (start && !active) begin
      active   <= 1'b1;
      done     <= 1'b0;
      addr     <= base;
      stride_q <= stride;
      vl_q     <= vlen;
      iss_cnt  <= '0;
      wr_cnt   <= '0;
    end else if (active) begin
      if (issue) begin
        addr    <= addr + stride_q;
        iss_cnt <= iss_cnt + 1'b1;
      end
      if (ret_valid) begin
        wr_cnt <= wr_cnt + 1'b1;
        if (wr_cnt == vl_q - 1'b1) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk)
    if (active && ret_valid) vreg[wr_cnt[IDX_W-1:0]] <= ret_data;

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    assign bank_req[g] = issue && (tgt == BSEL_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt[g] <= '0;
      else if (bank_req[g]) cnt[g] <= CNT_W'(BUSY - 1);
      else if (cnt[g] != 0) cnt[g] <= cnt[g] - 1'b1;
    end

    assert_req_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bank_req[g] |-> cnt[g] == '0);
    assert_no_back_to_back_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bank_req[g] |=> !bank_req[g]);
  end

  assert_single_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_req));
  assert_stall_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> bank_req == '0);
  assert_done_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (bank_req == '0 && !stall));
  assert_done_after_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(ret_valid));
endmodule

// File: tb/test_strided_vload_ctrl.sv
`timescale 1ns/1ps
module test_strided_vload_ctrl;
  localparam int BUSY = 7;
  logic clk = 0, rst_n = 0, start = 0, ret_valid = 0;
  logic [15:0] base = 0, stride = 0;
  logic [6:0]  vlen = 1;
  logic [7:0]  bank_req;
  logic [12:0] bank_row;
  logic        stall, done;
  logic [31:0] ret_data = 0, rd_data;
  logic [5:0]  rd_idx = 0;
  int checks = 0, fails = 0, cycles = 0;

  strided_vload_ctrl i_strided_vload_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .base(base), .stride(stride),
    .vlen(vlen), .bank_req(bank_req), .bank_row(bank_row), .stall(stall),
    .ret_valid(ret_valid), .ret_data(ret_data), .rd_idx(rd_idx),
    .rd_data(rd_data), .done(done));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: act=%0d exp<150000 cycles", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic logic [31:0] memw(input logic [15:0] a);
    return {a ^ 16'hA5C3, a} + 32'h0001_0F00;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input logic [15:0] b, input logic [15:0] s,
                         input int vl, input bit mid_start, output int stalls);
    int mcnt [8];
    int mi = 0, seq_err = 0, first_bad = -1, guard = 0, rd_err = 0;
    logic [15:0] maddr = b;
    bit pv = 0;
    logic [31:0] pd = 0;
    stalls = 0;
    foreach (mcnt[k]) mcnt[k] = 0;
    @(negedge clk);
    base = b; stride = s; vlen = 7'(vl); start = 1;
    @(negedge clk);
    start = 0;
    chk(done == 0, "R6", "done low while running", done, 0);
    while (mi < vl || pv) begin
      logic [7:0] er;
      bit es;
      int ib;
      guard++;
      if (guard > 2000) break;
      ib = -1;
      er = 0; es = 0;
      if (mi < vl) begin
        int bk = int'(maddr[2:0]);
        if (mcnt[bk] == 0) begin
          er = 8'(1 << bk); ib = bk;
          if (bank_row != maddr[15:3]) begin seq_err++; if (first_bad < 0) first_bad = mi; end
        end else begin
          es = 1; stalls++;
        end
      end
      if (bank_req != er || stall != es) begin seq_err++; if (first_bad < 0) first_bad = mi; end
      if (mid_start && guard == 3) begin
        start = 1; base = 16'h7777; stride = 16'h0003; vlen = 7'd5;
      end else start = 0;
      ret_valid = pv; ret_data = pd;
      pv = 0;
      foreach (mcnt[k]) if (mcnt[k] != 0) mcnt[k]--;
      if (ib >= 0) begin
        mcnt[ib] = BUSY - 1;
        pv = 1; pd = memw(maddr);
        mi++; maddr = maddr + s;
      end
      @(negedge clk);
    end
    ret_valid = 0; start = 0;
    // R1 R2 R3 R4 R9 R10: cycle-by-cycle request and stall sequence
    chk(seq_err == 0, "R1/R2/R3/R4", "request mismatches, first at element", first_bad, -1);
    // R6: last word captured one edge ago
    chk(done == 1, "R6", "done after last word", done, 1);
    for (int e = 0; e < vl; e++) begin
      logic [15:0] a = b + 16'(e) * s;
      rd_idx = 6'(e); #1;
      if (rd_data != memw(a)) begin
        rd_err++;
        if (rd_err == 1) chk(0, "R5", "vector slot data", rd_data, memw(a));
      end
    end
    if (rd_err == 0) chk(1, "R5", "vector slots", 0, 0);
    repeat (8) @(negedge clk);
    chk(done == 1 && bank_req == 0, "R6", "done held while idle", done, 1);
  endtask

  initial begin
    int st;
    void'($urandom(32'd1234));
    #12 rst_n = 1;
    @(negedge clk);
    chk(bank_req == 0, "R7", "bank_req after reset", bank_req, 0);
    chk(stall == 0, "R7", "stall after reset", stall, 0);
    chk(done == 0, "R7", "done after reset", done, 0);

    run_vec(16'h0010, 16'd1, 64, 0, st);
    chk(st == 0, "R4", "stride 1 stall cycles", st, 0);
    run_vec(16'h0123, 16'd8, 20, 0, st);
    chk(st == 19 * (BUSY - 1), "R4", "stride 8 stall cycles", st, 19 * (BUSY - 1));
    run_vec(16'h0040, 16'd8, 64, 0, st);
    chk(st == 63 * (BUSY - 1), "R4", "stride 8 len 64 stall cycles", st, 63 * (BUSY - 1));
    run_vec(16'h0005, 16'd2, 16, 0, st);
    chk(st > 0, "R3", "stride 2 revisits bank early", st, 1);
    run_vec(16'hFFFE, 16'd3, 12, 0, st);
    chk(st == 0, "R1", "wrapping stride 3 no stalls", st, 0);
    run_vec(16'h0200, 16'd4, 1, 0, st);
    chk(st == 0, "R8", "length 1 single request", st, 0);
    run_vec(16'h0300, 16'd16, 10, 1, st);
    chk(st == 9 * (BUSY - 1), "R9", "start during run ignored", st, 9 * (BUSY - 1));

    for (int n = 0; n < 20; n++) begin
      logic [15:0] rb, rs;
      int rl;
      rb = 16'($urandom);
      case ($urandom_range(0, 3))
        0: rs = 16'd1;
        1: rs = 16'd8 * 16'($urandom_range(1, 4));
        2: rs = 16'($urandom_range(2, 7));
        default: rs = 16'($urandom);
      endcase
      rl = $urandom_range(1, 64);
      run_vec(rb, rs, rl, 0, st);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule